// File: doc/BRIEF.md
# Sixteen-Pin GPIO with Interrupts and Two Clock Outputs

The block gives software sixteen I/O pins behind a small register file. Every pin has an output-enable bit and an output-data bit, and every pin's input can be read back after a two-flop synchroniser. Only the lower thirteen pins (0 to 12) can raise interrupts. Each of these pins has its own type: active-high level, active-low level, rising edge, falling edge or either edge. Level status follows the pin. Edge status is sticky and is cleared by writing ones to it. One request line is the OR of the enabled status bits.

The two top pins (14 and 15) can each be handed to their own clock generator. Each generator has a 16-bit period-minus-one field and a 16-bit high-time field. A counter runs from 0 up to the period value and wraps. The output is high while the counter is below the high time. New settings are held in a shadow and take effect only at a wrap, so a change never produces a runt pulse. The fastest clock is half the block clock.

Registers are written with `we_i`, `addr_i` and `wdata_i` in a single cycle. `rdata_o` is the combinational read of the register selected by `addr_i`.

Top module: `gpio_clkout`

## Requirements
- R1: After reset every register reads 0, `gpio_oe_o`, `gpio_o` and `irq_o` are 0, and neither clock generator is selected.
- R2: Direction register (address 0x0, 1 = drive) and output register (address 0x1) set `gpio_oe_o` and `gpio_o` bit for bit on every pin not handed to a clock generator, and both read back as written.
- R3: Address 0x2 reads the pins through a two-flop synchroniser: a change on `gpio_i` is visible after the second rising clock edge and not after the first.
- R4: Only pins 0 to 12 can interrupt. Enable (0x3), status (0x4) and type bits for pins 13 to 15 read 0, and those pins never set status. Type fields are 3 bits at bit 4*k of address 0x5 for pins 0 to 7 and at bit 4*(k-8) of address 0x6 for pins 8 to 12.
- R5: Type 0 (active high) and type 1 (active low) make the status bit follow the synchronised level. A write of 1 to a level status bit has no effect. Codes 5 to 7 never set status.
- R6: Type 2 (rising), type 3 (falling) and type 4 (both) set a sticky status bit one cycle after the synchronised change. The bit holds until a 1 is written to it at address 0x4. When an edge and a clear fall in the same cycle, the edge wins.
- R7: `irq_o` is high exactly when some status bit has its enable bit set. Status is recorded even when the pin is not enabled.
- R8: Setting bit 0 (pin 14) or bit 1 (pin 15) of address 0x7 makes that pin an output carrying its generator's clock, with output enable 1. The two generators run independently. Clearing the bit returns the pin to the direction and output registers.
- R9: With a generator config word {high[31:16], pm1[15:0]} (address 0x8 for pin 14, 0x9 for pin 15), the clock period is max(pm1,1)+1 cycles and the high time is min(high, period) cycles per period.
- R10: A config write to a running generator takes effect only when its counter wraps. Every complete high or low run is therefore the length it has under either the old or the new setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| gpio_i | input | 16 | Pin inputs |
| gpio_o | output | 16 | Pin output data |
| gpio_oe_o | output | 16 | Pin output enables |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a config change that lands part way through a clock period. The bench sets up a slow clock, waits for a settled phase, and writes a fast config at each of eight successive offsets into the period. At each offset it measures every complete high and low run and requires each run to match the old or the new setting. The same-cycle edge and clear race is reached by timing the clear write to the cycle in which a second rising edge leaves the synchroniser.

// File: rtl/gpio_clkout_pkg.sv
package gpio_clkout_pkg;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned TYPE_W = 3;

  localparam logic [ADDR_W-1:0] REG_DIR     = 4'h0;
  localparam logic [ADDR_W-1:0] REG_OUT     = 4'h1;
  localparam logic [ADDR_W-1:0] REG_IN      = 4'h2;
  localparam logic [ADDR_W-1:0] REG_IEN     = 4'h3;
  localparam logic [ADDR_W-1:0] REG_ISTAT   = 4'h4;
  localparam logic [ADDR_W-1:0] REG_ITYPE_A = 4'h5;
  localparam logic [ADDR_W-1:0] REG_ITYPE_B = 4'h6;
  localparam logic [ADDR_W-1:0] REG_CKSEL   = 4'h7;
  localparam logic [ADDR_W-1:0] REG_CK_BASE = 4'h8;

  localparam logic [TYPE_W-1:0] IRQ_HIGH = 3'd0;
  localparam logic [TYPE_W-1:0] IRQ_LOW  = 3'd1;
  localparam logic [TYPE_W-1:0] IRQ_RISE = 3'd2;
  localparam logic [TYPE_W-1:0] IRQ_FALL = 3'd3;
  localparam logic [TYPE_W-1:0] IRQ_BOTH = 3'd4;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_irq_det.sv
module gpio_irq_det
  import gpio_clkout_pkg::*;
#(
  parameter int unsigned NUM = 13
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM-1:0]             pin_i,
  input  logic [NUM-1:0][TYPE_W-1:0] type_i,
  input  logic [NUM-1:0]             clr_i,
  output logic [NUM-1:0]             stat_o
);
  for (genvar k = 0; k < NUM; k++) begin : g_pin
    logic prev_q, sticky_q, rise, fall, edge_hit, level_hit;

    assign rise = pin_i[k] & ~prev_q;
    assign fall = ~pin_i[k] & prev_q;

    always_comb begin
      edge_hit  = 1'b0;
      level_hit = 1'b0;
      case (type_i[k])
        IRQ_HIGH: level_hit = pin_i[k];
        IRQ_LOW:  level_hit = ~pin_i[k];
        IRQ_RISE: edge_hit  = rise;
        IRQ_FALL: edge_hit  = fall;
        IRQ_BOTH: edge_hit  = rise | fall;
        default: ;
      endcase
    end

    // set has priority over a same-cycle clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q   <= 1'b0;
        sticky_q <= 1'b0;
      end else begin
        prev_q <= pin_i[k];
        if (edge_hit)      sticky_q <= 1'b1;
        else if (clr_i[k]) sticky_q <= 1'b0;
      end
    end

    assign stat_o[k] = sticky_q | level_hit;
  end
endmodule

// File: rtl/gpio_clk_gen.sv
module gpio_clk_gen #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] per_m1_i,
  input  logic [CNT_W-1:0] high_i,
  output logic             clk_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] per_o
);
  logic [CNT_W-1:0] cnt_q, per_q, high_q, per_req;
  logic             out_q, wrap;

  // period floor of two block cycles
  assign per_req = (per_m1_i == '0) ? CNT_W'(1) : per_m1_i;
  assign wrap    = (cnt_q >= per_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      per_q  <= CNT_W'(1);
      high_q <= '0;
      out_q  <= 1'b0;
    end else if (!en_i) begin
      cnt_q  <= '0;
      per_q  <= per_req;
      high_q <= high_i;
      out_q  <= 1'b0;
    end else begin
      out_q <= (cnt_q < high_q);
      if (wrap) begin
        cnt_q  <= '0;
        per_q  <= per_req;
        high_q <= high_i;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign clk_o = out_q;
  assign cnt_o = cnt_q;
  assign per_o = per_q;
endmodule

// File: rtl/gpio_clkout.sv
module gpio_clkout
  import gpio_clkout_pkg::*;
#(
  parameter int unsigned NUM_PINS = 16,
  parameter int unsigned NUM_IRQ  = 13,
  parameter int unsigned NUM_CLK  = 2,
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned DATA_W   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [3:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [NUM_PINS-1:0] gpio_i,
  output logic [NUM_PINS-1:0] gpio_o,
  output logic [NUM_PINS-1:0] gpio_oe_o,
  output logic              irq_o
);
  localparam int unsigned CLK_BASE = NUM_PINS - NUM_CLK;
  localparam int unsigned TPR      = DATA_W / 4;

  logic [NUM_PINS-1:0]              dir_q, out_q, sync_w;
  logic [NUM_IRQ-1:0]               ien_q, stat_w, clr_w;
  logic [NUM_IRQ-1:0][TYPE_W-1:0]   itype_q;
  logic [NUM_CLK-1:0]               cksel_q, ck_out_w;
  logic [NUM_CLK-1:0][CNT_W-1:0]    ckper_q, ckhigh_q, ck_cnt_w, ck_per_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q    <= '0;
      out_q    <= '0;
      ien_q    <= '0;
      itype_q  <= '0;
      cksel_q  <= '0;
      ckper_q  <= '0;
      ckhigh_q <= '0;
    end else if (we_i) begin
      if (addr_i == REG_DIR)   dir_q   <= wdata_i[NUM_PINS-1:0];
      if (addr_i == REG_OUT)   out_q   <= wdata_i[NUM_PINS-1:0];
      if (addr_i == REG_IEN)   ien_q   <= wdata_i[NUM_IRQ-1:0];
      if (addr_i == REG_CKSEL) cksel_q <= wdata_i[NUM_CLK-1:0];
      for (int k = 0; k < NUM_IRQ; k++) begin
        if (addr_i == ((k < TPR) ? REG_ITYPE_A : REG_ITYPE_B))
          itype_q[k] <= wdata_i[(k % TPR)*4 +: TYPE_W];
      end
      for (int c = 0; c < NUM_CLK; c++) begin
        if (addr_i == REG_CK_BASE + 4'(c)) begin
          ckper_q[c]  <= wdata_i[CNT_W-1:0];
          ckhigh_q[c] <= wdata_i[2*CNT_W-1:CNT_W];
        end
      end
    end
  end

  assign clr_w = (we_i && addr_i == REG_ISTAT) ? wdata_i[NUM_IRQ-1:0] : '0;

  gpio_sync #(.W(NUM_PINS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (gpio_i),
    .q_o   (sync_w)
  );

  gpio_irq_det #(.NUM(NUM_IRQ)) u_irq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (sync_w[NUM_IRQ-1:0]),
    .type_i(itype_q),
    .clr_i (clr_w),
    .stat_o(stat_w)
  );

  for (genvar c = 0; c < NUM_CLK; c++) begin : g_ck
    gpio_clk_gen #(.CNT_W(CNT_W)) u_gen (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (cksel_q[c]),
      .per_m1_i(ckper_q[c]),
      .high_i  (ckhigh_q[c]),
      .clk_o   (ck_out_w[c]),
      .cnt_o   (ck_cnt_w[c]),
      .per_o   (ck_per_w[c])
    );
  end

  always_comb begin
    gpio_oe_o = dir_q;
    gpio_o    = out_q;
    for (int c = 0; c < NUM_CLK; c++) begin
      if (cksel_q[c]) begin
        gpio_oe_o[CLK_BASE+c] = 1'b1;
        gpio_o[CLK_BASE+c]    = ck_out_w[c];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      REG_DIR:   rdata_o[NUM_PINS-1:0] = dir_q;
      REG_OUT:   rdata_o[NUM_PINS-1:0] = out_q;
      REG_IN:    rdata_o[NUM_PINS-1:0] = sync_w;
      REG_IEN:   rdata_o[NUM_IRQ-1:0]  = ien_q;
      REG_ISTAT: rdata_o[NUM_IRQ-1:0]  = stat_w;
      REG_CKSEL: rdata_o[NUM_CLK-1:0]  = cksel_q;
      default: ;
    endcase
    for (int k = 0; k < NUM_IRQ; k++) begin
      if (addr_i == ((k < TPR) ? REG_ITYPE_A : REG_ITYPE_B))
        rdata_o[(k % TPR)*4 +: TYPE_W] = itype_q[k];
    end
    for (int c = 0; c < NUM_CLK; c++) begin
      if (addr_i == REG_CK_BASE + 4'(c))
        rdata_o[2*CNT_W-1:0] = {ckhigh_q[c], ckper_q[c]};
    end
  end

  assign irq_o = |(stat_w & ien_q);
endmodule

// File: rtl/gpio_clkout_chk.sv
module gpio_clkout_chk
  import gpio_clkout_pkg::*;
#(
  parameter int unsigned NUM_PINS = 16,
  parameter int unsigned NUM_IRQ  = 13,
  parameter int unsigned NUM_CLK  = 2,
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned DATA_W   = 32
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           we_i,
  input logic [3:0]                     addr_i,
  input logic [DATA_W-1:0]              wdata_i,
  input logic [DATA_W-1:0]              rdata_o,
  input logic [NUM_PINS-1:0]            gpio_i,
  input logic [NUM_PINS-1:0]            gpio_oe_o,
  input logic                           irq_o,
  input logic [NUM_CLK-1:0]             cksel_q,
  input logic [NUM_IRQ-1:0]             stat_w,
  input logic [NUM_IRQ-1:0]             ien_q,
  input logic [NUM_IRQ-1:0][TYPE_W-1:0] itype_q,
  input logic [NUM_CLK-1:0][CNT_W-1:0]  ck_cnt_w,
  input logic [NUM_CLK-1:0][CNT_W-1:0]  ck_per_w
);
  logic [1:0]         cyc_q;
  logic [NUM_IRQ-1:0] edge_mask, clr_mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cyc_q <= '0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
  end

  always_comb begin
    for (int k = 0; k < NUM_IRQ; k++)
      edge_mask[k] = (itype_q[k] == IRQ_RISE) || (itype_q[k] == IRQ_FALL) ||
                     (itype_q[k] == IRQ_BOTH);
  end
  assign clr_mask = (we_i && addr_i == REG_ISTAT) ? wdata_i[NUM_IRQ-1:0] : '0;

  a_r3_in_two_stage: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd2 && addr_i == REG_IN) |-> rdata_o[NUM_PINS-1:0] == $past(gpio_i, 2));

  a_r6_edge_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q != 2'd0) |->
      (($past(stat_w) & $past(edge_mask) & ~$past(clr_mask)) & ~stat_w) == '0);

  a_r7_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien_q == '0) |-> !irq_o);

  for (genvar c = 0; c < NUM_CLK; c++) begin : g_ck
    a_r8_pin_driven: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cksel_q[c] |-> gpio_oe_o[NUM_PINS-NUM_CLK+c]);

    a_r9_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ck_per_w[c] != '0) && (ck_cnt_w[c] <= ck_per_w[c]));

    a_r10_cfg_at_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cyc_q != 2'd0 && cksel_q[c] && $past(cksel_q[c]) && ck_per_w[c] != $past(ck_per_w[c]))
        |-> $past(ck_cnt_w[c]) == $past(ck_per_w[c]));
  end
endmodule

bind gpio_clkout gpio_clkout_chk #(
  .NUM_PINS(NUM_PINS),
  .NUM_IRQ (NUM_IRQ),
  .NUM_CLK (NUM_CLK),
  .CNT_W   (CNT_W),
  .DATA_W  (DATA_W)
) u_chk (.*);

// File: tb/gpio_clkout_test.sv
module gpio_clkout_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [15:0] gpio_i = '0;
  logic [15:0] gpio_o, gpio_oe_o;
  logic        irq_o;

  int n_chk = 0;
  int n_fail = 0;

  gpio_clkout uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .gpio_i(gpio_i),
    .gpio_o(gpio_o), .gpio_oe_o(gpio_oe_o), .irq_o(irq_o)
  );

  always #5 clk_i = ~clk_i;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    we_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk_i);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic quiesce();
    wr(4'h5, 32'h7777_7777);
    wr(4'h6, 32'h0007_7777);
    wr(4'h3, 32'h0);
    @(negedge clk_i);
    gpio_i = '0;
    settle();
    wr(4'h4, 32'h1FFF);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 10; a++) begin
      rd(4'(a), d);
      check($sformatf("R1 reg %0d", a), d, 32'h0);
    end
    check("R1 oe", {16'h0, gpio_oe_o}, 32'h0);
    check("R1 out", {16'h0, gpio_o}, 32'h0);
    check("R1 irq", {31'h0, irq_o}, 32'h0);
  endtask

  task automatic t_out();
    logic [31:0] d;
    wr(4'h0, 32'h0000_C0F5);
    wr(4'h1, 32'h0000_A0A5);
    @(negedge clk_i);
    check("R2 oe", {16'h0, gpio_oe_o}, 32'h0000_C0F5);
    check("R2 out", {16'h0, gpio_o}, 32'h0000_A0A5);
    rd(4'h0, d); check("R2 dir readback", d, 32'h0000_C0F5);
    rd(4'h1, d); check("R2 out readback", d, 32'h0000_A0A5);
  endtask

  task automatic t_in();
    logic [31:0] d;
    @(negedge clk_i);
    addr_i = 4'h2;
    gpio_i = 16'h5A3C;
    @(posedge clk_i);
    @(negedge clk_i);
    check("R3 after one edge", rdata_o, 32'h0);
    @(posedge clk_i);
    @(negedge clk_i);
    check("R3 after two edges", rdata_o, 32'h0000_5A3C);
    gpio_i = 16'h0;
    settle();
    rd(4'h2, d); check("R3 cleared", d, 32'h0);
  endtask

  task automatic t_cap();
    logic [31:0] d;
    quiesce();
    rd(4'h6, d); check("R4 type B width", d, 32'h0007_7777);
    wr(4'h3, 32'hFFFF_FFFF);
    rd(4'h3, d); check("R4 enable width", d, 32'h0000_1FFF);
    wr(4'h3, 32'h0);
    wr(4'h6, 32'h0002_2222);
    @(negedge clk_i);
    gpio_i = 16'hF000;
    settle();
    rd(4'h4, d); check("R4 only pin 12 sets", d, 32'h0000_1000);
    quiesce();
  endtask

  task automatic t_level();
    logic [31:0] d;
    quiesce();
    wr(4'h5, 32'h7777_7710);
    wr(4'h3, 32'h3);
    @(negedge clk_i); gpio_i = 16'h0002; settle();
    rd(4'h4, d); check("R5 inactive levels", d, 32'h0);
    check("R5 irq low", {31'h0, irq_o}, 32'h0);
    @(negedge clk_i); gpio_i = 16'h0001; settle();
    rd(4'h4, d); check("R5 both active", d, 32'h3);
    check("R5 irq high", {31'h0, irq_o}, 32'h1);
    wr(4'h4, 32'h3);
    rd(4'h4, d); check("R5 clear ignored", d, 32'h3);
    @(negedge clk_i); gpio_i = 16'h0000; settle();
    rd(4'h4, d); check("R5 follows level", d, 32'h2);
    wr(4'h5, 32'h7777_7755);
    rd(4'h4, d); check("R5 code 5 silent", d, 32'h0);
    quiesce();
  endtask

  task automatic t_edge();
    logic [31:0] d;
    quiesce();
    wr(4'h5, 32'h7774_3277);
    @(negedge clk_i); gpio_i = 16'h001C; settle();
    rd(4'h4, d); check("R6 rise and both", d, 32'h14);
    @(negedge clk_i); gpio_i = 16'h0000; settle();
    rd(4'h4, d); check("R6 fall added", d, 32'h1C);
    settle();
    rd(4'h4, d); check("R6 sticky", d, 32'h1C);
    wr(4'h4, 32'h04);
    rd(4'h4, d); check("R6 single clear", d, 32'h18);
    wr(4'h4, 32'h04);
    @(negedge clk_i); gpio_i = 16'h0004;
    wr(4'h4, 32'h0);
    settle();
    // bit 2 set again; now race a clear against a fresh rising edge
    @(negedge clk_i); gpio_i = 16'h0000; settle();
    @(negedge clk_i); gpio_i = 16'h0004;
    @(posedge clk_i);
    @(posedge clk_i);
    wr(4'h4, 32'h04);
    rd(4'h4, d); check("R6 edge wins over clear", d & 32'h4, 32'h4);
    wr(4'h4, 32'h1C);
    rd(4'h4, d); check("R6 all cleared", d, 32'h0);
    quiesce();
  endtask

  task automatic t_mask();
    logic [31:0] d;
    quiesce();
    wr(4'h5, 32'h7727_7777);
    @(negedge clk_i); gpio_i = 16'h0020; settle();
    rd(4'h4, d); check("R7 status while masked", d, 32'h20);
    check("R7 irq masked", {31'h0, irq_o}, 32'h0);
    wr(4'h3, 32'h20);
    @(negedge clk_i);
    check("R7 irq enabled", {31'h0, irq_o}, 32'h1);
    wr(4'h4, 32'h20);
    check("R7 irq after clear", {31'h0, irq_o}, 32'h0);
    quiesce();
  endtask

  task automatic count_high(input int pin, input int n, output int highs);
    highs = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      if (gpio_o[pin]) highs++;
    end
  endtask

  task automatic t_clk();
    int h;
    wr(4'h0, 32'h0);
    wr(4'h1, 32'h0);
    wr(4'h8, {16'd3, 16'd7});
    wr(4'h9, {16'd1, 16'd0});
    wr(4'h7, 32'h3);
    repeat (20) @(posedge clk_i);
    @(negedge clk_i);
    check("R8 oe both clocks", {16'h0, gpio_oe_o}, 32'h0000_C000);
    count_high(14, 64, h); check("R9 pin14 8/3", 32'(h), 32'd24);
    count_high(15, 64, h); check("R9 pin15 clamped period", 32'(h), 32'd32);
    wr(4'h8, {16'd0, 16'd7});
    wr(4'h9, {16'd5, 16'd0});
    repeat (20) @(posedge clk_i);
    count_high(14, 64, h); check("R9 zero high", 32'(h), 32'd0);
    count_high(15, 64, h); check("R9 high over period", 32'(h), 32'd64);
    wr(4'h8, {16'd20, 16'd7});
    repeat (20) @(posedge clk_i);
    count_high(14, 64, h); check("R9 high beyond period", 32'(h), 32'd64);
    wr(4'h7, 32'h1);
    wr(4'h0, 32'h0000_8000);
    wr(4'h1, 32'h0000_0000);
    @(negedge clk_i);
    check("R8 pin15 back to gpio", {16'h0, gpio_oe_o}, 32'h0000_C000);
    check("R8 pin15 data", {31'h0, gpio_o[15]}, 32'h0);
    wr(4'h7, 32'h0);
    wr(4'h0, 32'h0);
    @(negedge clk_i);
    check("R8 both released", {16'h0, gpio_oe_o}, 32'h0);
  endtask

  task automatic t_runt();
    for (int off = 0; off < 8; off++) begin
      int run, bad, first;
      logic prev;
      wr(4'h8, {16'd4, 16'd7});
      wr(4'h7, 32'h1);
      repeat (24 + off) @(posedge clk_i);
      wr(4'h8, {16'd1, 16'd1});
      bad = 0; run = 0; first = 1;
      @(negedge clk_i); prev = gpio_o[14];
      for (int i = 0; i < 40; i++) begin
        @(negedge clk_i);
        run++;
        if (gpio_o[14] != prev) begin
          if (!first && run != 1 && run != 4) bad++;
          first = 0; run = 0; prev = gpio_o[14];
        end
      end
      check($sformatf("R10 odd run lengths at offset %0d", off), 32'(bad), 32'd0);
      wr(4'h7, 32'h0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_out();
    t_in();
    t_cap();
    t_level();
    t_edge();
    t_mask();
    t_clk();
    t_runt();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule